// File: doc/BRIEF.md
# CAN Transmit Error Monitor

This block watches a CAN transmitter one bit at a time. On every sample strobe it compares the bit the transmitter put on the wire with the bit read back from the bus. An external frame sequencer supplies a code naming the current frame segment. From these inputs the block sorts each bit into one of four outcomes: clean, acknowledge error, form error or bit error. It also reports lost arbitration. Every error increments an 8-bit transmit error counter. When that count passes 96, a warning flag and an error interrupt are raised.

The block also owns the transmit handshake with the host. The host posts a request. The block grants the bus to the sequencer through `tx_enable`. On any error it withdraws that grant, flags the failure and keeps the request pending. It then waits for eleven consecutive recessive bits on the bus before it grants the bus again. A clean end of frame retires the request and raises a completion flag. The block does not drive error frames itself; it only pulses `err_frame_req` for whatever logic does.

Top module: `can_tx_err_mon`

## Requirements
- R1: Bits are judged only while `tx_enable` is high and `bit_stb` is high. Bit value 0 is dominant and 1 is recessive. The segment code is: 0 arbitration, 1 control/data, 2 CRC, 3 CRC delimiter, 4 ACK slot, 5 ACK delimiter, 6 end-of-frame, 7 interframe space. Each judged bit yields at most one of the four outcome pulses (`bit_err`, `form_err`, `ack_err`, `arb_lost`), and each pulse lasts one cycle.
- R2: Each acknowledge, form or bit error raises `tec` by exactly one. Arbitration loss and clean bits leave it unchanged.
- R3: When an error takes `tec` above 96, `tx_warn` and `err_if` are set, and `irq` (which follows `err_if`) goes high.
- R4: In the ACK slot with a recessive bit sent, a recessive readback is an acknowledge error. It starts a retry and does not pulse `err_frame_req`.
- R5: A dominant readback in segment 3, 5, 6 or 7 is a form error. It pulses `err_frame_req` and starts a retry.
- R6: Sending dominant and reading recessive is a bit error in every segment, and it pulses `err_frame_req`.
- R7: Sending recessive and reading dominant is a bit error only in segments 1 and 2. In segment 4 it is a good acknowledge. In segment 0 it pulses `arb_lost`, releases the bus and starts the idle wait, but does not count as an error.
- R8: A host request pulse sets `tx_req` and clears `tx_err` and `done_if`. From idle, `tx_enable` rises on the second clock edge after the pulse.
- R9: On any error, `tx_enable` drops, `tx_err` is set and `tx_req` stays high, all on the edge that latches the error.
- R10: After a failed attempt, `tx_enable` stays low until 11 consecutive recessive strobed bits have been seen. A dominant bit restarts the count. The bus is granted again one cycle after the eleventh bit.
- R11: A clean strobed bit with `frame_last` high while transmitting clears `tx_req`, sets `done_if` and drops `tx_enable`.
- R12: `tec` saturates at 255 and falls by one on `err_dec`, stopping at 0. `tx_warn` clears on `warn_clr` or when `tec` falls to 96 or below. `err_if` clears only on `warn_clr`.
- R13: After reset, all flags are low, `tec` is zero and the handshake is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe at each bus sample point |
| seg_code | input | 3 | Current frame segment from the sequencer |
| tx_bit | input | 1 | Bit driven by the transmitter (0 dominant) |
| rx_bit | input | 1 | Bit sampled back from the bus |
| frame_last | input | 1 | Marks the final bit of a frame, qualified by bit_stb |
| req_set | input | 1 | Host pulse that posts a transmit request |
| warn_clr | input | 1 | Host pulse that clears warning and error interrupt |
| err_dec | input | 1 | External pulse that lowers the error count by one |
| tx_enable | output | 1 | Bus granted to the sequencer |
| tx_req | output | 1 | Transmit request pending |
| tx_err | output | 1 | Last attempt failed |
| done_if | output | 1 | Transmission completed flag |
| bit_err | output | 1 | Bit error pulse |
| form_err | output | 1 | Form error pulse |
| ack_err | output | 1 | Acknowledge error pulse |
| arb_lost | output | 1 | Arbitration lost pulse |
| err_frame_req | output | 1 | Request to signal an error frame |
| tec | output | 8 | Transmit error count |
| tx_warn | output | 1 | Error count above warning limit |
| err_if | output | 1 | Error interrupt flag |
| irq | output | 1 | Interrupt line |

## Verification
The bench targets the segment boundaries where one readback means different things. A recessive-sent, dominant-read bit is a lost arbitration in segment 0, a good acknowledge in segment 4 and a bit error in segment 1; a design that mixed these up would count arbitration losses or penalise every acknowledged frame. It also checks that an acknowledge error never asks for an error frame. The idle wait is run with a dominant bit at position ten, to catch a counter that does not restart or that stops one bit short. The error count is walked across 96 in both directions and driven into saturation. An off-by-one limit, a warning that never clears on decrement, or a count that wraps to zero would each show up as a wrong flag or count value.

// File: rtl/can_txmon_pkg.sv
// Package: shared types for the CAN transmit error monitor.
// Assumes bit value 0 is dominant and 1 is recessive on the bus.
package can_txmon_pkg;

    // Frame segment codes supplied by the external sequencer.
    typedef enum logic [2:0] {
        SEG_ARB     = 3'd0,
        SEG_CTRL    = 3'd1,
        SEG_CRC     = 3'd2,
        SEG_CRC_DLM = 3'd3,
        SEG_ACK     = 3'd4,
        SEG_ACK_DLM = 3'd5,
        SEG_EOF     = 3'd6,
        SEG_IFS     = 3'd7
    } seg_t;

    // Handshake states.
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_TX   = 2'd1,
        HS_WAIT = 2'd2
    } hs_state_t;

    // One-hot-or-none outcome of a judged bit.
    typedef struct packed {
        logic bit_e;
        logic form_e;
        logic ack_e;
        logic arb;
    } verdict_t;

endpackage

// File: rtl/txmon_classify.sv
// Module: txmon_classify
// Judges one sampled bit against the bit sent and the frame segment, and
// registers the outcome as one-cycle pulses. Assumes the sequencer keeps
// seg_code stable while bit_stb is high. Only judges while active is high.
module txmon_classify
    import can_txmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     active,
    input  logic     bit_stb,
    input  logic [2:0] seg_code,
    input  logic     tx_bit,
    input  logic     rx_bit,
    output verdict_t verdict_now,
    output logic     any_err_now,
    output verdict_t verdict_q,
    output logic     ef_req_q
);

    seg_t seg;
    logic judge;
    logic form_seg;
    logic rec_checked_seg;

    assign seg             = seg_t'(seg_code);
    assign judge           = active && bit_stb;
    assign form_seg        = (seg == SEG_CRC_DLM) || (seg == SEG_ACK_DLM) ||
                             (seg == SEG_EOF) || (seg == SEG_IFS);
    assign rec_checked_seg = (seg == SEG_CTRL) || (seg == SEG_CRC);

    // Priority chain: bit error, form error, ack error, arbitration loss.
    always_comb begin
        verdict_now = '0;
        if (judge) begin
            if (!tx_bit && rx_bit)
                verdict_now.bit_e = 1'b1;
            else if (form_seg && !rx_bit)
                verdict_now.form_e = 1'b1;
            else if (seg == SEG_ACK && tx_bit && rx_bit)
                verdict_now.ack_e = 1'b1;
            else if (seg == SEG_ARB && tx_bit && !rx_bit)
                verdict_now.arb = 1'b1;
            else if (rec_checked_seg && tx_bit && !rx_bit)
                verdict_now.bit_e = 1'b1;
        end
    end

    assign any_err_now = verdict_now.bit_e || verdict_now.form_e || verdict_now.ack_e;

    // Register the verdict as one-cycle output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= '0;
            ef_req_q  <= 1'b0;
        end else begin
            verdict_q <= verdict_now;
            ef_req_q  <= verdict_now.bit_e || verdict_now.form_e;
        end
    end

    // R4: an acknowledge error never comes with an error-frame request.
    p_ack_no_ef_r4: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_q.ack_e |-> !ef_req_q);

    // R1: at most one outcome pulse per judged bit.
    p_one_verdict_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({verdict_q.bit_e, verdict_q.form_e, verdict_q.ack_e, verdict_q.arb}));

endmodule

// File: rtl/txmon_errcnt.sv
// Module: txmon_errcnt
// Saturating transmit error counter with a warning threshold and an
// error interrupt flag. Assumes inc and dec are single-cycle pulses.
module txmon_errcnt #(
    parameter int TEC_W    = 8,
    parameter int WARN_LIM = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic             warn_clr,
    output logic [TEC_W-1:0] tec,
    output logic             tx_warn,
    output logic             err_if
);

    localparam logic [TEC_W-1:0] LIM_V = TEC_W'(WARN_LIM);
    localparam logic [TEC_W-1:0] MAX_V = {TEC_W{1'b1}};

    logic [TEC_W-1:0] tec_n;
    logic             up;

    assign up = inc && !dec;

    // Next count: saturate high on increment, floor at zero on decrement.
    always_comb begin
        tec_n = tec;
        if (up && tec != MAX_V)
            tec_n = tec + 1'b1;
        else if (dec && !inc && tec != '0)
            tec_n = tec - 1'b1;
    end

    // Update the count and the warning and interrupt flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tec     <= '0;
            tx_warn <= 1'b0;
            err_if  <= 1'b0;
        end else begin
            tec <= tec_n;
            if (up && tec_n > LIM_V) begin
                tx_warn <= 1'b1;
                err_if  <= 1'b1;
            end else begin
                if (warn_clr || tec_n <= LIM_V)
                    tx_warn <= 1'b0;
                if (warn_clr)
                    err_if <= 1'b0;
            end
        end
    end

    // R2: one error adds exactly one below saturation.
    p_inc_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && tec != MAX_V) |=> (tec == $past(tec) + 1'b1));

    // R12: the count holds at its maximum.
    p_saturate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && tec == MAX_V) |=> (tec == MAX_V));

    // R3: the warning only rises with the count above the limit.
    p_warn_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_warn) |-> (tec > LIM_V && err_if));

endmodule

// File: rtl/txmon_handshake.sv
// Module: txmon_handshake
// Host request, bus grant, failure release, idle-bus wait and completion.
// Assumes err_in and arb_in are only high while the bus is granted.
module txmon_handshake
    import can_txmon_pkg::*;
#(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic err_in,
    input  logic arb_in,
    input  logic bit_stb,
    input  logic rx_bit,
    input  logic frame_last,
    output logic tx_enable,
    output logic tx_req,
    output logic tx_err,
    output logic done_if
);

    localparam int CNT_W = $clog2(IDLE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(IDLE_BITS - 1);

    hs_state_t        state;
    logic [CNT_W-1:0] idle_cnt;

    assign tx_enable = (state == HS_TX);

    // Handshake state machine with request and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= HS_IDLE;
            idle_cnt <= '0;
            tx_req   <= 1'b0;
            tx_err   <= 1'b0;
            done_if  <= 1'b0;
        end else begin
            if (req_set) begin
                tx_req  <= 1'b1;
                tx_err  <= 1'b0;
                done_if <= 1'b0;
            end
            unique case (state)
                HS_IDLE: begin
                    if (tx_req)
                        state <= HS_TX;
                end
                HS_TX: begin
                    if (err_in) begin
                        state    <= HS_WAIT;
                        tx_err   <= 1'b1;
                        idle_cnt <= '0;
                    end else if (arb_in) begin
                        state    <= HS_WAIT;
                        idle_cnt <= '0;
                    end else if (bit_stb && frame_last) begin
                        state   <= HS_IDLE;
                        tx_req  <= 1'b0;
                        done_if <= 1'b1;
                    end
                end
                HS_WAIT: begin
                    if (bit_stb) begin
                        if (!rx_bit)
                            idle_cnt <= '0;
                        else if (idle_cnt == LAST_V) begin
                            idle_cnt <= '0;
                            state    <= HS_IDLE;
                        end else
                            idle_cnt <= idle_cnt + 1'b1;
                    end
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

    // R9: an error releases the bus and keeps the request pending.
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_in |=> (!tx_enable && tx_req && tx_err));

    // R10: a dominant bit during the wait restarts the idle count.
    p_idle_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_WAIT && bit_stb && !rx_bit) |=> (state == HS_WAIT && idle_cnt == '0));

    // R11: completion is never flagged with a request still pending.
    p_done_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_if) |-> !tx_req);

    // R8: a request without a coincident error leaves the status clear.
    p_req_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_set && !err_in) |=> (tx_req && !tx_err));

endmodule

// File: rtl/can_tx_err_mon.sv
// Module: can_tx_err_mon
// Top of the transmit error monitor: bit judge, error counter and host
// handshake. Assumes one bit_stb per bus bit and a sequencer that only
// transmits while tx_enable is high.
module can_tx_err_mon
    import can_txmon_pkg::*;
#(
    parameter int TEC_W     = 8,
    parameter int WARN_LIM  = 96,
    parameter int IDLE_BITS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic [2:0]       seg_code,
    input  logic             tx_bit,
    input  logic             rx_bit,
    input  logic             frame_last,
    input  logic             req_set,
    input  logic             warn_clr,
    input  logic             err_dec,
    output logic             tx_enable,
    output logic             tx_req,
    output logic             tx_err,
    output logic             done_if,
    output logic             bit_err,
    output logic             form_err,
    output logic             ack_err,
    output logic             arb_lost,
    output logic             err_frame_req,
    output logic [TEC_W-1:0] tec,
    output logic             tx_warn,
    output logic             err_if,
    output logic             irq
);

    verdict_t verdict_now;
    verdict_t verdict_q;
    logic     any_err_now;

    txmon_classify u_classify (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (tx_enable),
        .bit_stb     (bit_stb),
        .seg_code    (seg_code),
        .tx_bit      (tx_bit),
        .rx_bit      (rx_bit),
        .verdict_now (verdict_now),
        .any_err_now (any_err_now),
        .verdict_q   (verdict_q),
        .ef_req_q    (err_frame_req)
    );

    txmon_errcnt #(
        .TEC_W    (TEC_W),
        .WARN_LIM (WARN_LIM)
    ) u_errcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (any_err_now),
        .dec      (err_dec),
        .warn_clr (warn_clr),
        .tec      (tec),
        .tx_warn  (tx_warn),
        .err_if   (err_if)
    );

    txmon_handshake #(
        .IDLE_BITS (IDLE_BITS)
    ) u_handshake (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_set    (req_set),
        .err_in     (any_err_now),
        .arb_in     (verdict_now.arb),
        .bit_stb    (bit_stb),
        .rx_bit     (rx_bit),
        .frame_last (frame_last),
        .tx_enable  (tx_enable),
        .tx_req     (tx_req),
        .tx_err     (tx_err),
        .done_if    (done_if)
    );

    assign bit_err  = verdict_q.bit_e;
    assign form_err = verdict_q.form_e;
    assign ack_err  = verdict_q.ack_e;
    assign arb_lost = verdict_q.arb;
    assign irq      = err_if;

    // R7: arbitration loss never asks for an error frame or counts.
    p_arb_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> (!err_frame_req && tec == $past(tec)));

endmodule

// File: tb/can_tx_err_mon_tb.sv
// Bench for can_tx_err_mon: directed corner cases plus seeded random bits.
module can_tx_err_mon_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic [2:0] seg_code = 3'd0;
    logic       tx_bit = 1'b1;
    logic       rx_bit = 1'b1;
    logic       frame_last = 1'b0;
    logic       req_set = 1'b0;
    logic       warn_clr = 1'b0;
    logic       err_dec = 1'b0;
    logic       tx_enable, tx_req, tx_err, done_if;
    logic       bit_err, form_err, ack_err, arb_lost, err_frame_req;
    logic [7:0] tec;
    logic       tx_warn, err_if, irq;

    int checks = 0;
    int fails = 0;
    int exp_tec = 0;
    bit exp_warn = 0;
    bit exp_eif = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_tx_err_mon dut_i (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .seg_code(seg_code),
        .tx_bit(tx_bit), .rx_bit(rx_bit), .frame_last(frame_last),
        .req_set(req_set), .warn_clr(warn_clr), .err_dec(err_dec),
        .tx_enable(tx_enable), .tx_req(tx_req), .tx_err(tx_err), .done_if(done_if),
        .bit_err(bit_err), .form_err(form_err), .ack_err(ack_err), .arb_lost(arb_lost),
        .err_frame_req(err_frame_req), .tec(tec), .tx_warn(tx_warn),
        .err_if(err_if), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected outcome: 0 none, 1 bit, 2 form, 3 ack, 4 arbitration lost.
    function automatic int judge(input int seg, input bit tx, input bit rx);
        if (!tx && rx) return 1;
        if ((seg == 3 || seg >= 5) && !rx) return 2;
        if (seg == 4 && tx && rx) return 3;
        if (seg == 0 && tx && !rx) return 4;
        if ((seg == 1 || seg == 2) && tx && !rx) return 1;
        return 0;
    endfunction

    // Expected count and flags after one error.
    task automatic model_err();
        if (exp_tec < 255) exp_tec++;
        if (exp_tec > 96) begin exp_warn = 1; exp_eif = 1; end
    endtask

    task automatic strobe(input int seg, input bit tx, input bit rx, input bit last);
        @(negedge clk);
        seg_code = 3'(seg); tx_bit = tx; rx_bit = rx; frame_last = last; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0; frame_last = 1'b0; tx_bit = 1'b1; rx_bit = 1'b1;
    endtask

    task automatic pulse_req();
        @(negedge clk); req_set = 1'b1;
        @(negedge clk); req_set = 1'b0;
    endtask

    task automatic retry();
        for (int i = 0; i < 11; i++) strobe(7, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
    endtask

    task automatic check_outcome(input string tag, input int kind);
        chk({tag, " bit_err"}, int'(bit_err), int'(kind == 1));
        chk({tag, " form_err"}, int'(form_err), int'(kind == 2));
        chk({tag, " ack_err"}, int'(ack_err), int'(kind == 3));
        chk({tag, " arb_lost"}, int'(arb_lost), int'(kind == 4));
        chk({tag, " err_frame_req"}, int'(err_frame_req), int'(kind == 1 || kind == 2));
        chk({tag, " tec"}, int'(tec), exp_tec);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R13 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", fails, checks);
            $finish;
        end
    end

    initial begin
        int k;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 tec", int'(tec), 0);
        chk("R13 tx_enable", int'(tx_enable), 0);
        chk("R13 tx_req", int'(tx_req), 0);
        chk("R13 warn", int'(tx_warn), 0);
        chk("R13 irq", int'(irq), 0);

        // R1 bits ignored without a grant
        strobe(5, 1'b1, 1'b0, 1'b0);
        check_outcome("R1 idle ignore", 0);

        // R8 request raises grant on second edge
        pulse_req();
        chk("R8 tx_req", int'(tx_req), 1);
        chk("R8 not yet enabled", int'(tx_enable), 0);
        @(negedge clk);
        chk("R8 tx_enable", int'(tx_enable), 1);

        // R7 good ack and recessive-dominant in arbitration
        strobe(4, 1'b1, 1'b0, 1'b0);
        check_outcome("R7 ack ok", 0);
        strobe(1, 1'b1, 1'b0, 1'b0);
        model_err();
        check_outcome("R7 ctrl rec/dom", 1);
        retry();
        strobe(0, 1'b1, 1'b0, 1'b0);
        check_outcome("R7 arb lost", 4);
        chk("R7 released", int'(tx_enable), 0);
        retry();
        chk("R7 regrant", int'(tx_enable), 1);

        // R4 acknowledge error
        strobe(4, 1'b1, 1'b1, 1'b0);
        model_err();
        check_outcome("R4 ack err", 3);
        chk("R9 released", int'(tx_enable), 0);
        chk("R9 tx_err", int'(tx_err), 1);
        chk("R9 req kept", int'(tx_req), 1);

        // R10 idle wait restarted by a dominant bit
        for (int i = 0; i < 10; i++) strobe(7, 1'b1, 1'b1, 1'b0);
        strobe(7, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) strobe(7, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk("R10 ten bits not enough", int'(tx_enable), 0);
        strobe(7, 1'b1, 1'b1, 1'b0);
        chk("R10 eleventh bit", int'(tx_enable), 0);
        @(negedge clk);
        chk("R10 regrant", int'(tx_enable), 1);

        // R5 form error in each checked segment, R6 bit error
        for (int s = 3; s <= 7; s++) begin
            if (s == 4) continue;
            strobe(s, 1'b1, 1'b0, 1'b0);
            model_err();
            check_outcome($sformatf("R5 form seg%0d", s), 2);
            pulse_req();
            chk("R8 tx_err cleared", int'(tx_err), 0);
            retry();
        end
        strobe(0, 1'b0, 1'b1, 1'b0);
        model_err();
        check_outcome("R6 bit err arb", 1);
        retry();

        // R11 clean completion
        strobe(7, 1'b1, 1'b1, 1'b1);
        chk("R11 done_if", int'(done_if), 1);
        chk("R11 tx_req", int'(tx_req), 0);
        chk("R11 tx_enable", int'(tx_enable), 0);
        pulse_req();
        chk("R8 done cleared", int'(done_if), 0);
        @(negedge clk);

        // R3 cross the warning limit
        while (exp_tec < 96) begin
            strobe(4, 1'b1, 1'b1, 1'b0);
            model_err();
            retry();
        end
        chk("R3 tec 96", int'(tec), 96);
        chk("R3 no warn at 96", int'(tx_warn), 0);
        strobe(4, 1'b1, 1'b1, 1'b0);
        model_err();
        chk("R3 tec 97", int'(tec), 97);
        chk("R3 warn", int'(tx_warn), 1);
        chk("R3 err_if", int'(err_if), 1);
        chk("R3 irq", int'(irq), 1);
        retry();

        // R12 decrement drops warning, host write clears interrupt
        @(negedge clk); err_dec = 1'b1;
        @(negedge clk); err_dec = 1'b0;
        exp_tec = 96; exp_warn = 0;
        chk("R12 dec tec", int'(tec), 96);
        chk("R12 warn dropped", int'(tx_warn), 0);
        chk("R12 err_if held", int'(err_if), 1);
        @(negedge clk); warn_clr = 1'b1;
        @(negedge clk); warn_clr = 1'b0;
        exp_eif = 0;
        chk("R12 err_if cleared", int'(err_if), 0);
        chk("R12 irq cleared", int'(irq), 0);

        // Random bits against the model
        for (int it = 0; it < 250; it++) begin
            int seg;
            bit tx, rx;
            seg = int'($urandom_range(0, 7));
            tx = 1'($urandom_range(0, 3) != 0);
            rx = 1'($urandom_range(0, 1));
            strobe(seg, tx, rx, 1'b0);
            k = judge(seg, tx, rx);
            if (k >= 1 && k <= 3) model_err();
            check_outcome($sformatf("R1 rand seg%0d tx%0d rx%0d", seg, tx, rx), k);
            chk("R3 rand warn", int'(tx_warn), int'(exp_warn));
            chk("R3 rand err_if", int'(err_if), int'(exp_eif));
            if (k != 0) begin
                chk("R9 rand released", int'(tx_enable), 0);
                retry();
            end
        end

        // R12 saturation
        while (exp_tec < 257) begin
            strobe(2, 1'b0, 1'b1, 1'b0);
            exp_tec++;
            retry();
        end
        chk("R12 saturated", int'(tec), 255);
        chk("R12 warn at max", int'(tx_warn), 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

endmodule